// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block is a clocked sequencer that sits between a simple internal request port and an external asynchronous static RAM with a 19-bit address and an 8-bit data path. A requester presents an address, write data and a direction flag together with `req_valid`. The request is taken in any cycle where `req_ready` is high. The controller then runs one complete single access on the memory pins. It drives an active-low select and an active-high select, an active-low output enable and an active-low write enable. The data bus is split into an output value, an output-enable and an input value, so that a pad ring can build the tri-state bus.

Every memory timing limit is a nanosecond parameter. Each one is turned into a cycle count by rounding up against the clock period. Each strobe phase has its own down-counter: write pulse width, select-to-end-of-write, data setup before the end of write, read access, and bus turnaround after a read. So each limit is met on its own terms and not by one shared wait. Read data comes back on `rd_data` with a one-cycle `rd_valid` strobe.

Top module: `asram_ctl`

## Requirements
- R1: While `rst_n` is low, both selects are inactive (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low from the cycle after acceptance through the final recovery cycle. With 8 ns defaults this is 8 cycles for a read, 8 for a write that follows a write or reset, and 10 for a write that follows a read.
- R3: A read asserts both selects with `mem_oe_n`=0 and `mem_we_n`=1 for max(ceil(tAA/T), ceil(tOE/T)) cycles, which is 7 cycles at the defaults.
- R4: Read data is sampled on the last output-enable cycle. `rd_valid` is high for exactly one cycle, the first cycle after output enable rises, and `rd_data` then holds the addressed byte.
- R5: In a write, `mem_we_n` stays low for at least ceil(tWP/T) cycles (5). The selects are active for at least ceil(tCW/T) cycles (6) before `mem_we_n` rises. `mem_oe_n` never goes low at the same time as `mem_we_n`.
- R6: The controller drives the data bus for at least ceil(tDW/T) cycles (4) of write-enable-low before write enable rises. It keeps driving in the one cycle after the rise and stops in the cycle after that. It never drives while output enable is low.
- R7: After a read, the controller's data drivers stay off for the first ceil(tTURN/T) cycles (3) of write-enable-low. With the defaults this lengthens the write pulse to 7 cycles, with the first driven cycle being the 4th. A write that does not follow a read drives from the 1st cycle, with a 5-cycle pulse.
- R8: `mem_addr` and the driven write data are registered at acceptance and stay stable in every cycle where the selects are active, whatever the request port does meanwhile.
- R9: When `req_ready` is high, the memory is in standby: selects inactive, both enables high, and the bus not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe: rd_data is new |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 1 | Active-low select |
| mem_cs | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The in-module assertions run on every cycle and check the following:
- output enable and write enable are never low together;
- the minimum write-enable width is kept;
- the select-to-end-of-write span and the data-setup span are kept, each measured by its own run-length counter;
- the driver holds for exactly one cycle after write enable rises;
- the address stays stable under the selects;
- the read strobe lasts one cycle;
- the port sits in standby whenever it is ready.

The exact cycle counts can only be shown by the bench scenarios, which run reads, writes, writes after reads and reads after reads against a byte model. These counts are the 8- and 10-cycle busy times, the 7-cycle read window, the delayed first driven cycle after a read, and the strobe's cycle. The bench scenarios also show that the byte returned is the one stored last.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_W_SEL,
      ST_W_PULSE,
      ST_W_HOLD,
      ST_R_ACC,
      ST_REC
   } ctl_state_t;

   // Cycles needed to cover a nanosecond interval, rounded up.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      return (ns == 0) ? 0 : (ns + per - 1) / per;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_ctl_timer.sv
module asram_ctl_timer #(
   parameter int unsigned LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);

   logic [CW-1:0] cnt;

   initial begin
      assert (LEN >= 1) else $error("timer length must be at least one cycle");
   end

   // Loaded on the edge that opens the phase; done on the LEN-th cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= CW'(LEN - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/asram_ctl_seq.sv
module asram_ctl_seq
   import asram_ctl_pkg::*;
#(
   parameter int unsigned WP_CYC   = 5,
   parameter int unsigned CW_CYC   = 6,
   parameter int unsigned DW_CYC   = 4,
   parameter int unsigned ACC_CYC  = 7,
   parameter int unsigned TURN_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic req_ready,
   output logic accept,
   output logic capture,
   output logic cs_n,
   output logic cs,
   output logic oe_n,
   output logic we_n,
   output logic dq_oe
);
   localparam bit HAS_TURN = (TURN_CYC != 0);

   ctl_state_t st, st_nx;
   logic wp_done, cw_done, dw_done, acc_done, turn_done;
   logic ld_cw, ld_wp, ld_dw, ld_acc;
   logic drv_q, drv_set, after_rd_q;

   // ---------------- per-phase timers ----------------
   asram_ctl_timer #(.LEN(WP_CYC))  u_t_wp  (.clk(clk), .rst_n(rst_n), .load(ld_wp),  .done(wp_done));
   asram_ctl_timer #(.LEN(CW_CYC))  u_t_cw  (.clk(clk), .rst_n(rst_n), .load(ld_cw),  .done(cw_done));
   asram_ctl_timer #(.LEN(DW_CYC))  u_t_dw  (.clk(clk), .rst_n(rst_n), .load(ld_dw),  .done(dw_done));
   asram_ctl_timer #(.LEN(ACC_CYC)) u_t_acc (.clk(clk), .rst_n(rst_n), .load(ld_acc), .done(acc_done));

   generate
      if (HAS_TURN) begin : g_turn
         asram_ctl_timer #(.LEN(TURN_CYC)) u_t_turn (
            .clk(clk), .rst_n(rst_n), .load(ld_wp), .done(turn_done)
         );
      end else begin : g_no_turn
         assign turn_done = 1'b1;
      end
   endgenerate

   // ---------------- next state ----------------
   always_comb begin
      st_nx   = st;
      capture = 1'b0;
      unique case (st)
         ST_IDLE:    if (req_valid) st_nx = req_write ? ST_W_SEL : ST_R_ACC;
         ST_W_SEL:   st_nx = ST_W_PULSE;
         ST_W_PULSE: if (wp_done && cw_done && drv_q && dw_done) st_nx = ST_W_HOLD;
         ST_W_HOLD:  st_nx = ST_REC;
         ST_R_ACC:   if (acc_done) begin
                        capture = 1'b1;
                        st_nx   = ST_REC;
                     end
         ST_REC:     st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   assign req_ready = (st == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign ld_cw     = accept && req_write;
   assign ld_acc    = accept && !req_write;
   assign ld_wp     = (st == ST_W_SEL);
   assign drv_set   = ((st == ST_W_SEL) && (!after_rd_q || !HAS_TURN))
                   || ((st == ST_W_PULSE) && !drv_q && after_rd_q && turn_done);
   assign ld_dw     = drv_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         drv_q      <= 1'b0;
         after_rd_q <= 1'b0;
         cs_n       <= 1'b1;
         cs         <= 1'b0;
         oe_n       <= 1'b1;
         we_n       <= 1'b1;
      end else begin
         st <= st_nx;
         if (drv_set)               drv_q <= 1'b1;
         else if (st == ST_W_HOLD)  drv_q <= 1'b0;
         if (capture)               after_rd_q <= 1'b1;
         else if (st == ST_W_HOLD)  after_rd_q <= 1'b0;
         cs_n <= !(st_nx inside {ST_W_SEL, ST_W_PULSE, ST_W_HOLD, ST_R_ACC});
         cs   <=  (st_nx inside {ST_W_SEL, ST_W_PULSE, ST_W_HOLD, ST_R_ACC});
         oe_n <= !(st_nx == ST_R_ACC);
         we_n <= !(st_nx == ST_W_PULSE);
      end
   end

   assign dq_oe = drv_q;

   // ---------------- checks ----------------
   logic [15:0] we_run, sel_run, drv_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run  <= '0;
         sel_run <= '0;
         drv_run <= '0;
      end else begin
         we_run  <= we_n ? '0 : we_run + 1'b1;
         sel_run <= cs_n ? '0 : sel_run + 1'b1;
         drv_run <= (we_n || !dq_oe) ? '0 : drv_run + 1'b1;
      end
   end

   a_r5_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));
   a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (we_run >= 16'(WP_CYC)));
   a_r5_select_to_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (sel_run >= 16'(CW_CYC)));
   a_r6_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (drv_run >= 16'(DW_CYC)));
   a_r6_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> dq_oe);
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (we_n && $past(we_n)) |-> !dq_oe);
   a_r6_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n);
   a_r9_standby: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cs_n && !cs && oe_n && we_n && !dq_oe));
endmodule

// File: rtl/asram_ctl_datapath.sv
module asram_ctl_datapath #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic              sel_n,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
         end
         rd_valid <= capture;
         if (capture) rd_data <= mem_dq_i;
      end
   end

   a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && $past(!sel_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 19,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 8,
   parameter int unsigned T_WP_NS       = 40,
   parameter int unsigned T_CW_NS       = 45,
   parameter int unsigned T_DW_NS       = 25,
   parameter int unsigned T_AA_NS       = 55,
   parameter int unsigned T_OE_NS       = 25,
   parameter int unsigned T_TURN_NS     = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
   localparam int unsigned CW_CYC   = ns_to_cyc(T_CW_NS, CLK_PERIOD_NS);
   localparam int unsigned DW_CYC   = ns_to_cyc(T_DW_NS, CLK_PERIOD_NS);
   localparam int unsigned ACC_CYC  = umax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
   localparam int unsigned TURN_CYC = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);

   initial begin
      assert (CLK_PERIOD_NS > 0) else $error("clock period must be nonzero");
      assert (ADDR_W >= 1 && DATA_W >= 1) else $error("bus widths must be nonzero");
      assert (WP_CYC >= 1 && CW_CYC >= 1) else $error("write strobe intervals must be nonzero");
      assert (DW_CYC >= 1 && ACC_CYC >= 1) else $error("setup and access intervals must be nonzero");
   end

   logic accept, capture;

   asram_ctl_seq #(
      .WP_CYC(WP_CYC), .CW_CYC(CW_CYC), .DW_CYC(DW_CYC),
      .ACC_CYC(ACC_CYC), .TURN_CYC(TURN_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
      .accept(accept), .capture(capture),
      .cs_n(mem_cs_n), .cs(mem_cs), .oe_n(mem_oe_n), .we_n(mem_we_n),
      .dq_oe(mem_dq_oe)
   );

   asram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n),
      .accept(accept), .capture(capture), .sel_n(mem_cs_n),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );
endmodule

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb;
   localparam int PER  = 8;
   localparam int WP   = (40 + PER - 1) / PER;
   localparam int CWC  = (45 + PER - 1) / PER;
   localparam int DW   = (25 + PER - 1) / PER;
   localparam int AA   = (55 + PER - 1) / PER;
   localparam int OEC  = (25 + PER - 1) / PER;
   localparam int ACC  = (AA > OEC) ? AA : OEC;
   localparam int TURN = (20 + PER - 1) / PER;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [18:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rd_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0] rd_data, mem_dq_o, mem_dq_i;
   logic [18:0] mem_addr;

   always #4 clk = ~clk;

   asram_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] model [256];
   logic [7:0] shadow [256];
   logic [7:0] exp_q [$];
   bit last_was_read = 0;

   task automatic check(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // memory model: stores at the end of write, answers while read-enabled
   always_comb begin
      if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n) mem_dq_i = model[mem_addr[7:0]];
      else mem_dq_i = 8'h00;
   end
   always @(posedge mem_we_n) begin
      if (rst_n && !mem_cs_n && mem_cs) model[mem_addr[7:0]] = mem_dq_o;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R4 unexpected strobe: actual %0h expected none", rd_data);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (rd_data !== e) begin
               n_fail++;
               $display("FAIL R4 read data: actual %0h expected %0h", rd_data, e);
            end
         end
      end
   end

   task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d);
      int busy = 0, we_low = 0, drv_low = 0, first_drv = 0, oe_low = 0;
      int hold_drv = 0, late_drv = 0, addr_bad = 0, data_bad = 0, rv_at = 0, clash = 0;
      bit prev_we_low = 0;
      int exp_we, exp_first;
      @(negedge clk);
      check("R2 ready before request", int'(req_ready), 1);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      if (wr) shadow[a[7:0]] = d;
      else exp_q.push_back(shadow[a[7:0]]);
      @(negedge clk);
      req_valid = 0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
      while (!req_ready) begin
         busy++;
         if (!mem_cs_n && mem_addr != a) addr_bad++;
         if (!mem_oe_n) oe_low++;
         if (!mem_oe_n && mem_dq_oe) clash++;
         if (!mem_we_n) begin
            we_low++;
            if (mem_dq_oe) begin
               drv_low++;
               if (first_drv == 0) first_drv = we_low;
               if (mem_dq_o != d) data_bad++;
            end
         end else if (prev_we_low) hold_drv = int'(mem_dq_oe);
         else if (mem_dq_oe) late_drv++;
         prev_we_low = !mem_we_n;
         if (rd_valid) rv_at = busy;
         @(negedge clk);
      end
      check("R9 standby selects", int'({mem_cs_n, mem_cs}), 2);
      check("R9 standby enables", int'({mem_oe_n, mem_we_n, mem_dq_oe}), 6);
      check("R8 address stable", addr_bad, 0);
      check("R6 no drive during output enable", clash, 0);
      if (wr) begin
         exp_we    = last_was_read ? ((WP > TURN + DW) ? WP : TURN + DW) : WP;
         if (CWC - 1 > exp_we) exp_we = CWC - 1;
         exp_first = last_was_read ? TURN + 1 : 1;
         check("R5 write pulse cycles", we_low, exp_we);
         check("R5 output enable high in write", oe_low, 0);
         check("R7 first driven cycle", first_drv, exp_first);
         check("R6 driven cycles before end", drv_low, exp_we - exp_first + 1);
         check("R6 drive held one cycle", hold_drv, 1);
         check("R6 released after hold", late_drv, 0);
         check("R8 write data stable", data_bad, 0);
         check("R2 write busy cycles", busy, exp_we + 3);
         check("R5 stored byte", int'(model[a[7:0]]), int'(d));
         last_was_read = 0;
      end else begin
         check("R3 output enable cycles", oe_low, ACC);
         check("R3 write enable high in read", we_low, 0);
         check("R4 strobe cycle", rv_at, ACC + 1);
         check("R2 read busy cycles", busy, ACC + 1);
         last_was_read = 1;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         model[i]  = 8'(i) ^ 8'h5A;
         shadow[i] = 8'(i) ^ 8'h5A;
      end
      repeat (3) @(negedge clk);
      check("R1 selects in reset", int'({mem_cs_n, mem_cs}), 2);
      check("R1 enables in reset", int'({mem_oe_n, mem_we_n, mem_dq_oe}), 6);
      rst_n = 1;
      @(negedge clk);
      check("R9 ready after reset", int'(req_ready), 1);
      access(1, 19'h00010, 8'hA5);
      access(1, 19'h7FF23, 8'hFF);
      access(0, 19'h00010, 8'h00);
      access(1, 19'h00044, 8'h00);
      access(0, 19'h7FF23, 8'h00);
      access(0, 19'h00044, 8'h00);
      access(0, 19'h000C7, 8'h00);
      access(1, 19'h00000, 8'h3C);
      access(1, 19'h000C7, 8'h81);
      access(0, 19'h00000, 8'h00);
      access(0, 19'h000C7, 8'h00);
      repeat (3) @(negedge clk);
      check("R4 all reads returned", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule